// File: doc/BRIEF.md
# Shared Work-RAM Ownership and Bank Mode Register

This block holds the control register through which a main processor and a sub processor divide a shared work RAM and through which the main side picks which program-RAM bank it sees. The main side writes it with byte writes (low byte only) or word writes (both bytes). The sub side does not write it through the bus here. Its two actions, raising the return bit and setting the mode bit, reach the block as plain strobes.

The register holds a write-protect byte, a two-bit bank select, a mode bit that chooses between a two-bank and a one-bank arrangement of the work RAM, a hand-over request bit and a return bit. The hand-over request bit is written differently in each mode. In two-bank mode, writing it as 1 gives the RAM to the sub processor. In one-bank mode, writing 1 only records a pending return, and writing 0 actually sets the bit.

Every main-side write sends a one-cycle synchronisation pulse toward the sub processor. When the RAM passes to the sub side, a second one-cycle pulse lets a waiting sub-side agent resume.

Top module: `wram_mode_ctrl`

## Requirements
- R1: After reset, the read value, the bank base, the owner, the pending flag and both pulses are all zero. This state is two-bank mode with the main side owning the RAM.
- R2: Read bits 7:6 hold the bank select. `bank_base` equals the bank select times 131072 (bank select shifted left by 17).
- R3: `rd_data` carries the write-protect byte in bits 15:8 and the low byte in bits 7:0. The low byte holds bank in 7:6, mode in bit 2, request in bit 1 and return in bit 0. Bits 5:3 always read 0, even after a write that sets them.
- R4: With mode=1, a main write with data bit 1 = 1 sets `ret_pending` and leaves bits 7:0 unchanged.
- R5: With mode=1, a main write with data bit 1 = 0 loads the bank from data bits 7:6 and forces the request bit to 1. The return bit is left as it was.
- R6: With mode=0, a main write with data bit 1 = 1 loads the bank, sets the request bit, clears the return bit and makes `ram_owner_sub` 1.
- R7: With mode=0, a main write with data bit 1 = 0 changes only the bank bits.
- R8: A word write loads the write-protect byte from data bits 15:8. A byte write leaves it unchanged.
- R9: `poll_sync` is high for exactly the one cycle after each main write, whether the write is a byte or a word write and whatever its data.
- R10: `own_chg` is high for one cycle when `ram_owner_sub` goes from 0 to 1. It stays low for a hand-over write while the sub side already owns the RAM.
- R11: A `sub_ret_wr` strobe sets the return bit, clears the request bit and gives the RAM to the main side. It overrides a hand-over write in the same cycle, and in that case no `own_chg` pulse is produced.
- R12: A `sub_mode_wr` strobe loads the mode bit from `sub_mode_val` and clears `ret_pending`. A main write in the same cycle is decoded with the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Main-side write strobe |
| wr_word | input | 1 | 1: word write, 0: byte write to the low byte |
| wr_data | input | 16 | Main-side write data |
| sub_ret_wr | input | 1 | Sub side raises the return bit |
| sub_mode_wr | input | 1 | Sub side writes the mode bit |
| sub_mode_val | input | 1 | Mode value for `sub_mode_wr` |
| rd_data | output | 16 | Masked main-side read value |
| bank_base | output | 19 | Byte offset of the selected program-RAM bank |
| ram_owner_sub | output | 1 | 1 when the sub side owns the work RAM |
| ret_pending | output | 1 | A return request was written in one-bank mode |
| own_chg | output | 1 | One-cycle pulse on hand-over to the sub side |
| poll_sync | output | 1 | One-cycle pulse after every main write |

## Verification
Two actions can land in the same cycle. A main hand-over write can meet the sub side's return strobe, and a main write can meet a sub-side mode change. A directed step drives the hand-over write and the return strobe on the same edge and expects the return to win, with the owner staying main and no hand-over pulse. The randomised phase then makes both collisions common. The bench compares every output against a behavioural model that first applies the main write with the old mode and then overlays the sub-side strobes.

// File: rtl/wram_mode_pkg.sv
package wram_mode_pkg;
  localparam int BANK_W     = 2;
  localparam int BANK_SHIFT = 17;
  localparam int WP_W       = 8;
  localparam int LO_W       = 8;
  localparam int RD_W       = WP_W + LO_W;
  localparam int BASE_W     = BANK_W + BANK_SHIFT;

  localparam int BIT_RET  = 0;
  localparam int BIT_REQ  = 1;
  localparam int BIT_MODE = 2;
  localparam int BIT_BANK = 6;

  typedef struct packed {
    logic [WP_W-1:0]   wprot;
    logic [BANK_W-1:0] bank;
    logic              mode;
    logic              req;
    logic              ret;
  } mode_state_t;
endpackage

// File: rtl/wram_mode_ctrl.sv
module wram_mode_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

module wram_mode_next
  import wram_mode_pkg::*;
(
  input  mode_state_t       cur,
  input  logic              owner_q,
  input  logic              pend_q,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [RD_W-1:0]   wr_data,
  input  logic              sub_ret_wr,
  input  logic              sub_mode_wr,
  input  logic              sub_mode_val,
  output mode_state_t       nxt,
  output logic              owner_d,
  output logic              pend_d,
  output logic              handover
);
  logic [BANK_W-1:0] wr_bank;
  logic              wr_req;

  assign wr_bank = wr_data[BIT_BANK +: BANK_W];
  assign wr_req  = wr_data[BIT_REQ];

  always_comb begin
    nxt     = cur;
    owner_d = owner_q;
    pend_d  = pend_q;

    // main-side write, decoded with the mode currently held
    if (wr_en) begin
      if (wr_word) begin
        nxt.wprot = wr_data[LO_W +: WP_W];
      end
      if (cur.mode) begin
        if (wr_req) begin
          pend_d = 1'b1;
        end else begin
          nxt.bank = wr_bank;
          nxt.req  = 1'b1;
        end
      end else begin
        nxt.bank = wr_bank;
        if (wr_req) begin
          nxt.req = 1'b1;
          nxt.ret = 1'b0;
          owner_d = 1'b1;
        end
      end
    end

    // sub-side strobes take effect after the main write
    if (sub_mode_wr) begin
      nxt.mode = sub_mode_val;
      pend_d   = 1'b0;
    end
    if (sub_ret_wr) begin
      nxt.ret = 1'b1;
      nxt.req = 1'b0;
      owner_d = 1'b0;
    end
  end

  assign handover = owner_d & ~owner_q;
endmodule

module wram_mode_regs
  import wram_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_en,
  input  mode_state_t nxt,
  input  logic        owner_d,
  input  logic        pend_d,
  input  logic        handover,
  input  logic        wr_en,
  output mode_state_t cur,
  output logic        owner_q,
  output logic        pend_q,
  output logic        own_chg_q,
  output logic        poll_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= '0;
      owner_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (upd_en) begin
      cur     <= nxt;
      owner_q <= owner_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_chg_q <= 1'b0;
      poll_q    <= 1'b0;
    end else begin
      own_chg_q <= handover;
      poll_q    <= wr_en;
    end
  end
endmodule

module wram_mode_view
  import wram_mode_pkg::*;
(
  input  mode_state_t       cur,
  output logic [RD_W-1:0]   rd_data,
  output logic [BASE_W-1:0] bank_base
);
  logic [LO_W-1:0] lo;

  always_comb begin
    lo                      = '0;
    lo[BIT_BANK +: BANK_W]  = cur.bank;
    lo[BIT_MODE]            = cur.mode;
    lo[BIT_REQ]             = cur.req;
    lo[BIT_RET]             = cur.ret;
  end

  assign rd_data   = {cur.wprot, lo};
  assign bank_base = BASE_W'(cur.bank) << BANK_SHIFT;
endmodule

module wram_mode_ctrl
  import wram_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [RD_W-1:0]   wr_data,
  input  logic              sub_ret_wr,
  input  logic              sub_mode_wr,
  input  logic              sub_mode_val,
  output logic [RD_W-1:0]   rd_data,
  output logic [BASE_W-1:0] bank_base,
  output logic              ram_owner_sub,
  output logic              ret_pending,
  output logic              own_chg,
  output logic              poll_sync
);
  logic        rst_int_n;
  mode_state_t cur;
  mode_state_t nxt;
  logic        owner_q;
  logic        owner_d;
  logic        pend_q;
  logic        pend_d;
  logic        handover;
  logic        upd_en;

  wram_mode_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign upd_en = wr_en | sub_ret_wr | sub_mode_wr;

  wram_mode_next u_next (
    .cur          (cur),
    .owner_q      (owner_q),
    .pend_q       (pend_q),
    .wr_en        (wr_en),
    .wr_word      (wr_word),
    .wr_data      (wr_data),
    .sub_ret_wr   (sub_ret_wr),
    .sub_mode_wr  (sub_mode_wr),
    .sub_mode_val (sub_mode_val),
    .nxt          (nxt),
    .owner_d      (owner_d),
    .pend_d       (pend_d),
    .handover     (handover)
  );

  wram_mode_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .upd_en    (upd_en),
    .nxt       (nxt),
    .owner_d   (owner_d),
    .pend_d    (pend_d),
    .handover  (handover),
    .wr_en     (wr_en),
    .cur       (cur),
    .owner_q   (owner_q),
    .pend_q    (pend_q),
    .own_chg_q (own_chg),
    .poll_q    (poll_sync)
  );

  wram_mode_view u_view (
    .cur       (cur),
    .rd_data   (rd_data),
    .bank_base (bank_base)
  );

  assign ram_owner_sub = owner_q;
  assign ret_pending   = pend_q;
endmodule

// File: rtl/wram_mode_ctrl_chk.sv
module wram_mode_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_word,
  input logic [15:0] wr_data,
  input logic        sub_ret_wr,
  input logic        sub_mode_wr,
  input logic [15:0] rd_data,
  input logic        ram_owner_sub,
  input logic        ret_pending,
  input logic        own_chg,
  input logic        poll_sync
);
  p_handover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_data[2] && wr_data[1] && !sub_ret_wr)
      |=> (ram_owner_sub && rd_data[1] && !rd_data[0]));

  p_return_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sub_ret_wr |=> (!ram_owner_sub && rd_data[0] && !rd_data[1] && !own_chg));

  p_sync_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> poll_sync);

  p_sync_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    poll_sync |-> $past(wr_en));

  p_pulse_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    own_chg |-> (ram_owner_sub && !$past(ram_owner_sub)));

  p_onebank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data[2] && wr_data[1] && !sub_ret_wr && !sub_mode_wr)
      |=> (ret_pending && $stable(rd_data[7:0])));

  p_onebank_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data[2] && !wr_data[1] && !sub_ret_wr)
      |=> (rd_data[1] && rd_data[7:6] == $past(wr_data[7:6])));

  p_byte_keeps_wp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word) |=> $stable(rd_data[15:8]));

  p_word_loads_wp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word) |=> (rd_data[15:8] == $past(wr_data[15:8])));

  p_hidden_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[5:3] == 3'b000));
endmodule

bind wram_mode_ctrl wram_mode_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .wr_en         (wr_en),
  .wr_word       (wr_word),
  .wr_data       (wr_data),
  .sub_ret_wr    (sub_ret_wr),
  .sub_mode_wr   (sub_mode_wr),
  .rd_data       (rd_data),
  .ram_owner_sub (ram_owner_sub),
  .ret_pending   (ret_pending),
  .own_chg       (own_chg),
  .poll_sync     (poll_sync)
);

// File: tb/wram_mode_ctrl_tb.sv
module wram_mode_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_word = 1'b0;
  logic [15:0] wr_data = '0;
  logic        sub_ret_wr = 1'b0;
  logic        sub_mode_wr = 1'b0;
  logic        sub_mode_val = 1'b0;
  logic [15:0] rd_data;
  logic [18:0] bank_base;
  logic        ram_owner_sub;
  logic        ret_pending;
  logic        own_chg;
  logic        poll_sync;

  int n_chk = 0;
  int n_err = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  // behavioural reference
  int m_wp, m_bank, m_mode, m_req, m_ret, m_own, m_pend, m_chg, m_poll;
  int rel_cnt = 0;

  always #5 clk = ~clk;

  wram_mode_ctrl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_word       (wr_word),
    .wr_data       (wr_data),
    .sub_ret_wr    (sub_ret_wr),
    .sub_mode_wr   (sub_mode_wr),
    .sub_mode_val  (sub_mode_val),
    .rd_data       (rd_data),
    .bank_base     (bank_base),
    .ram_owner_sub (ram_owner_sub),
    .ret_pending   (ret_pending),
    .own_chg       (own_chg),
    .poll_sync     (poll_sync)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || rel_cnt < 2) begin
      if (!rst_n) rel_cnt = 0;
      else        rel_cnt = rel_cnt + 1;
      m_wp = 0; m_bank = 0; m_mode = 0; m_req = 0; m_ret = 0;
      m_own = 0; m_pend = 0; m_chg = 0; m_poll = 0;
    end else begin
      int was_own;
      was_own = m_own;
      m_poll  = wr_en ? 1 : 0;
      if (wr_en) begin
        if (wr_word) m_wp = wr_data[15:8];
        if (m_mode == 1) begin
          if (wr_data[1]) m_pend = 1;
          else begin m_bank = wr_data[7:6]; m_req = 1; end
        end else begin
          m_bank = wr_data[7:6];
          if (wr_data[1]) begin m_req = 1; m_ret = 0; m_own = 1; end
        end
      end
      if (sub_mode_wr) begin m_mode = sub_mode_val; m_pend = 0; end
      if (sub_ret_wr) begin m_ret = 1; m_req = 0; m_own = 0; end
      m_chg = (m_own == 1 && was_own == 0) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk("R3 rd_data", int'(rd_data),
          (m_wp << 8) | (m_bank << 6) | (m_mode << 2) | (m_req << 1) | m_ret);
      chk("R2 bank_base", int'(bank_base), m_bank * 131072);
      chk("R6 owner", int'(ram_owner_sub), m_own);
      chk("R10 own_chg", int'(own_chg), m_chg);
      chk("R9 poll_sync", int'(poll_sync), m_poll);
      chk("R4 ret_pending", int'(ret_pending), m_pend);
    end
  end

  task automatic step(input bit we, input bit ww, input logic [15:0] d,
                      input bit sr, input bit smw, input bit smv);
    wr_en = we; wr_word = ww; wr_data = d;
    sub_ret_wr = sr; sub_mode_wr = smw; sub_mode_val = smv;
    @(negedge clk);
    wr_en = 1'b0; sub_ret_wr = 1'b0; sub_mode_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset rd_data", int'(rd_data), 0);
    chk("R1 reset owner", int'(ram_owner_sub), 0);
    chk("R1 reset pulses", int'({own_chg, poll_sync, ret_pending}), 0);
    chk("R1 reset bank_base", int'(bank_base), 0);
    live = 1'b1;

    step(1, 0, 16'h00B8, 0, 0, 0);
    chk("R7 bank only, R3 hidden bits", int'(rd_data), 16'h0080);
    chk("R2 base of bank 2", int'(bank_base), 32'h40000);
    chk("R9 sync pulse", int'(poll_sync), 1);
    @(negedge clk);
    chk("R9 sync one cycle", int'(poll_sync), 0);

    step(1, 0, 16'h0042, 0, 0, 0);
    chk("R6 hand-over", int'({ram_owner_sub, rd_data[7:0]}), 9'h142);
    chk("R10 pulse on hand-over", int'(own_chg), 1);

    step(1, 0, 16'h0002, 0, 0, 0);
    chk("R10 no pulse when owned", int'(own_chg), 0);
    chk("R6 owner kept", int'(ram_owner_sub), 1);

    step(0, 0, 16'h0000, 1, 0, 0);
    chk("R11 return", int'({ram_owner_sub, rd_data[7:0]}), 9'h001);

    step(1, 1, 16'hA5C0, 0, 0, 0);
    chk("R8 word write", int'(rd_data), 16'hA5C1);

    step(1, 0, 16'h7700, 0, 0, 0);
    chk("R8 byte keeps wp", int'(rd_data), 16'hA501);

    step(0, 0, 16'h0000, 0, 1, 1);
    chk("R12 mode set", int'(rd_data), 16'hA505);

    step(1, 0, 16'h00C2, 0, 0, 0);
    chk("R4 one-bank return request", int'({ret_pending, rd_data}), 17'h1A505);

    step(1, 0, 16'h0040, 0, 0, 0);
    chk("R5 request forced", int'(rd_data), 16'hA547);

    step(0, 0, 16'h0000, 0, 1, 0);
    chk("R12 mode clear, pending cleared", int'({ret_pending, rd_data}), 17'h0A543);

    step(1, 0, 16'h0002, 1, 0, 0);
    chk("R11 return wins", int'({ram_owner_sub, own_chg, rd_data}), 18'h0A501);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) == 0, $urandom % 2, 16'($urandom),
           ($urandom % 9) == 0, ($urandom % 7) == 0, $urandom % 2);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
      $finish;
    end
  end
endmodule